// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers 32 level-sensitive interrupt sources and presents them to a processor as two active-low request lines: a fast line that carries no vector and a vectored line. Each source can be enabled on its own and routed to either line. Each source also has a handler-address register. When the vectored line is raised, the controller has already copied the handler address of the winning source into a current-address register. Software reads that register, branches to the handler, and ends servicing by writing any value back to it.

Enables are changed through two separate registers, one that sets bits and one that clears them, so software never needs a read-modify-write sequence. Controllers can be placed in series. A downstream controller hands its request and its vector to the chain input. The local sources of this controller rank above anything arriving on that input. The vectored line and the current address then serve as the request and vector passed to the next controller upstream.

All registers sit on a simple synchronous word-addressed bus with address, write strobe, write data and a registered read-data port.

Top module: `vec_intc`

## Requirements
- R1: After reset all enables, select bits and handler addresses are 0, `irq_n` and `fiq_n` are high, and `vec_o` is 0.
- R2: A write to offset 0x02 (enable-set) enables every source whose data bit is 1 and leaves the others unchanged. Reading offset 0x02 returns the enable bits.
- R3: A write to offset 0x03 (enable-clear) disables every source whose data bit is 1 and leaves the others unchanged. Offset 0x03 reads as 0.
- R4: Offset 0x00 reads the raw source levels. Offset 0x01 reads the sources that are both active and enabled.
- R5: Offset 0x04 holds one select bit per source: 1 routes the source to FIQ, 0 to IRQ. `fiq_n` is low, without any clock delay, exactly when an enabled source with select 1 is active.
- R6: Offsets 0x20 + i hold the handler address of source i. They are writable and read back unchanged.
- R7: When no interrupt is in service and an enabled IRQ-routed source is active, the next clock edge copies into the current-address register the handler address of the lowest-index such source, drives `irq_n` low, and presents that address on `vec_o`.
- R8: While an interrupt is in service, the current address and `irq_n` stay unchanged until the acknowledge write, even if a higher-priority source becomes active.
- R9: A write of any value to offset 0x05 (current address) ends servicing, and `irq_n` is high after that edge. A request that is still pending is latched again on the following edge.
- R10: Chain input: a local IRQ request ranks above `dc_req_i`. With no local request, `dc_vec_i` is latched as the current address. `dc_ack_o` is high during an acknowledge write only if the serviced interrupt came from the chain.
- R11: A read returns on `bus_rdata` the value of the register addressed on the previous clock edge. Offset 0x05 reads the current address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NSRC | Interrupt source levels, active high |
| bus_addr | input | ADDR_W | Word address of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data |
| dc_req_i | input | 1 | Request from a downstream controller |
| dc_vec_i | input | DW | Handler address from a downstream controller |
| dc_ack_o | output | 1 | Acknowledge to the downstream controller |
| irq_n | output | 1 | Vectored interrupt request, active low |
| fiq_n | output | 1 | Fast interrupt request, active low |
| vec_o | output | DW | Current handler address, the vector passed upstream |

## Verification
On every cycle, the assertions check the set and clear effect of enable writes, the one-hot lowest-index choice of the arbiter, the hold of the current address during service, and the release of `irq_n` after an acknowledge. Only the bench scenarios can show the actual handler values that get latched: the priority order between local sources and the chain, the stale-vector behaviour when a higher-priority request arrives late, the cycle-free path to `fiq_n`, and the readback contents of every register.

// File: rtl/vec_intc_pkg.sv
package vec_intc_pkg;
  // register word offsets
  localparam int OFS_RAW    = 'h00;
  localparam int OFS_MASKED = 'h01;
  localparam int OFS_ENSET  = 'h02;
  localparam int OFS_ENCLR  = 'h03;
  localparam int OFS_SEL    = 'h04;
  localparam int OFS_CUR    = 'h05;
  localparam int OFS_VEC    = 'h20;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_LOCAL = 2'd1,
    SRC_CHAIN = 2'd2
  } svc_origin_e;
endpackage

// File: rtl/vec_intc_regs.sv
module vec_intc_regs #(
  parameter int NSRC   = 32,
  parameter int ADDR_W = 8,
  parameter int DW     = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic                      bus_we,
  input  logic [DW-1:0]             bus_wdata,
  output logic [NSRC-1:0]           en_q,
  output logic [NSRC-1:0]           sel_q,
  output logic [NSRC-1:0][DW-1:0]   vec_q
);
  import vec_intc_pkg::*;

  localparam int VBASE = OFS_VEC;

  logic wr_enset, wr_enclr, wr_sel;
  logic [NSRC-1:0] vec_wr;

  assign wr_enset = bus_we && (bus_addr == ADDR_W'(OFS_ENSET));
  assign wr_enclr = bus_we && (bus_addr == ADDR_W'(OFS_ENCLR));
  assign wr_sel   = bus_we && (bus_addr == ADDR_W'(OFS_SEL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      sel_q <= '0;
    end else begin
      if (wr_enset)      en_q <= en_q |  bus_wdata[NSRC-1:0];
      else if (wr_enclr) en_q <= en_q & ~bus_wdata[NSRC-1:0];
      if (wr_sel)        sel_q <= bus_wdata[NSRC-1:0];
    end
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_vec
    assign vec_wr[g] = bus_we && (bus_addr == ADDR_W'(VBASE + g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         vec_q[g] <= '0;
      else if (vec_wr[g]) vec_q[g] <= bus_wdata;
    end
  end

  // R2
  enset_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_enset |=> ((en_q & $past(bus_wdata[NSRC-1:0])) == $past(bus_wdata[NSRC-1:0])));
  // R2
  enset_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_enset |=> ((en_q & ~$past(bus_wdata[NSRC-1:0])) == ($past(en_q) & ~$past(bus_wdata[NSRC-1:0]))));
  // R3
  enclr_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_enclr |=> ((en_q & $past(bus_wdata[NSRC-1:0])) == '0));
endmodule

// File: rtl/vec_intc_arb.sv
module vec_intc_arb #(
  parameter int NSRC = 32,
  localparam int IW  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req,
  output logic            any,
  output logic [IW-1:0]   win_idx,
  output logic [NSRC-1:0] win_oh
);
  // lowest set index wins
  function automatic logic [IW-1:0] lowest_idx(input logic [NSRC-1:0] r);
    logic [IW-1:0] k;
    k = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (r[i]) k = IW'(i);
    return k;
  endfunction

  assign any     = |req;
  assign win_idx = lowest_idx(req);
  assign win_oh  = any ? (NSRC'(1) << win_idx) : '0;

  // R7
  win_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_oh) && ((win_oh & ~req) == '0));
  // R7
  win_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> ((req & (win_oh - NSRC'(1))) == '0));
endmodule

// File: rtl/vec_intc.sv
module vec_intc #(
  parameter int NSRC   = 32,
  parameter int ADDR_W = 8,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_i,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              dc_req_i,
  input  logic [DW-1:0]     dc_vec_i,
  output logic              dc_ack_o,
  output logic              irq_n,
  output logic              fiq_n
  ,output logic [DW-1:0]    vec_o
);
  import vec_intc_pkg::*;

  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [NSRC-1:0]         en_q, sel_q;
  logic [NSRC-1:0][DW-1:0] vec_q;
  logic [NSRC-1:0]         masked, irq_req, win_oh;
  logic                    local_any, take, ack_wr;
  logic [IW-1:0]           win_idx;
  logic [DW-1:0]           cur_q, rd_next;
  svc_origin_e             origin_q;

  vec_intc_regs #(.NSRC(NSRC), .ADDR_W(ADDR_W), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .en_q(en_q), .sel_q(sel_q), .vec_q(vec_q)
  );

  assign masked  = src_i & en_q;
  assign irq_req = masked & ~sel_q;

  vec_intc_arb #(.NSRC(NSRC)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(irq_req),
    .any(local_any), .win_idx(win_idx), .win_oh(win_oh)
  );

  // named events for the checks
  assign ack_wr = bus_we && (bus_addr == ADDR_W'(OFS_CUR));
  assign take   = !ack_wr && (origin_q == SRC_NONE) && (local_any || dc_req_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      origin_q <= SRC_NONE;
      cur_q    <= '0;
    end else if (ack_wr) begin
      origin_q <= SRC_NONE;
    end else if (take) begin
      origin_q <= local_any ? SRC_LOCAL : SRC_CHAIN;
      cur_q    <= local_any ? vec_q[win_idx] : dc_vec_i;
    end
  end

  assign irq_n    = (origin_q == SRC_NONE);
  assign fiq_n    = ~|(masked & sel_q);
  assign vec_o    = cur_q;
  assign dc_ack_o = ack_wr && (origin_q == SRC_CHAIN);

  always_comb begin
    rd_next = '0;
    case (int'(bus_addr))
      OFS_RAW:    rd_next[NSRC-1:0] = src_i;
      OFS_MASKED: rd_next[NSRC-1:0] = masked;
      OFS_ENSET:  rd_next[NSRC-1:0] = en_q;
      OFS_SEL:    rd_next[NSRC-1:0] = sel_q;
      OFS_CUR:    rd_next = cur_q;
      default: begin
        for (int i = 0; i < NSRC; i++)
          if (int'(bus_addr) == OFS_VEC + i) rd_next = vec_q[i];
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= rd_next;
  end

  // R8
  cur_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n && !ack_wr) |=> (!irq_n && $stable(cur_q)));
  // R9
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_wr |=> irq_n);
  // R7
  raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_n && !ack_wr && local_any) |=> (!irq_n && cur_q == $past(vec_q[win_idx])));
  // R10
  chain_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dc_ack_o |-> (!irq_n && ack_wr));
endmodule

// File: tb/tb_vec_intc.sv
module tb_vec_intc;
  localparam int NSRC = 32;
  localparam int AW   = 8;
  localparam int DW   = 32;

  logic clk = 0, rst_n = 0;
  logic [NSRC-1:0] src_i = '0;
  logic [AW-1:0] bus_addr = '0;
  logic bus_we = 0;
  logic [DW-1:0] bus_wdata = '0, bus_rdata, dc_vec_i = '0, vec_o;
  logic dc_req_i = 0, dc_ack_o, irq_n, fiq_n;
  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] rv;

  always #10 clk = ~clk;

  vec_intc #(.NSRC(NSRC), .ADDR_W(AW), .DW(DW)) dut (.*);

  task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_addr = AW'(a); bus_wdata = d; bus_we = 1;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(input int a, output logic [DW-1:0] d);
    @(negedge clk);
    bus_addr = AW'(a);
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic t_reset;
    chk("R1 irq_n", irq_n, 1);
    chk("R1 fiq_n", fiq_n, 1);
    chk("R1 vec_o", vec_o, 0);
    rd('h02, rv); chk("R1 enables", rv, 0);
    rd('h21, rv); chk("R1 vector", rv, 0);
  endtask

  task automatic t_enables;
    wr('h02, 32'h0000_00F0);
    wr('h02, 32'h0000_0001);
    rd('h02, rv); chk("R2 set/no effect of 0", rv, 32'h0000_00F1);
    wr('h03, 32'h0000_0030);
    rd('h02, rv); chk("R3 clear", rv, 32'h0000_00C1);
    rd('h03, rv); chk("R3 reads zero", rv, 0);
  endtask

  task automatic t_status;
    @(negedge clk) src_i = 32'hFFFF_0041;
    rd('h00, rv); chk("R4 raw", rv, 32'hFFFF_0041);
    rd('h01, rv); chk("R4 masked", rv, 32'h0000_0041);
    @(negedge clk) src_i = '0;
    wr('h05, 0);
    chk("R9 idle after ack", irq_n, 1);
  endtask

  task automatic t_vectors;
    for (int i = 0; i < NSRC; i++) wr('h20 + i, 32'h1000 + i * 4);
    rd('h20, rv); chk("R6 vec0", rv, 32'h1000);
    rd('h31, rv); chk("R6 vec17", rv, 32'h1044);
    rd('h3F, rv); chk("R6 vec31", rv, 32'h107C);
  endtask

  task automatic t_fiq;
    wr('h04, 32'h80);
    rd('h04, rv); chk("R5 select readback", rv, 32'h80);
    @(negedge clk) src_i = 32'h80;
    #1 chk("R5 fiq_n low at once", fiq_n, 0);
    @(negedge clk) chk("R5 no irq for fiq source", irq_n, 1);
    wr('h03, 32'h80);
    #1 chk("R5 fiq_n high when disabled", fiq_n, 1);
    @(negedge clk) src_i = '0;
    wr('h04, 0);
  endtask

  task automatic t_priority;
    wr('h02, 32'h24);
    @(negedge clk) src_i = 32'h20;
    @(negedge clk);
    chk("R7 irq_n low", irq_n, 0);
    chk("R7 vector src5", vec_o, 32'h1014);
    src_i = 32'h24;
    @(negedge clk); @(negedge clk);
    chk("R8 vector held", vec_o, 32'h1014);
    chk("R8 irq_n held", irq_n, 0);
    rd('h05, rv); chk("R11 current read", rv, 32'h1014);
    wr('h05, 32'hDEAD);
    chk("R9 irq_n released", irq_n, 1);
    @(negedge clk);
    chk("R7 lowest index wins", vec_o, 32'h1008);
    chk("R9 relatch", irq_n, 0);
    src_i = '0;
    wr('h05, 0);
  endtask

  task automatic t_chain;
    @(negedge clk) begin dc_vec_i = 32'hC0DE_0000; dc_req_i = 1; end
    @(negedge clk);
    chk("R10 chain vector", vec_o, 32'hC0DE_0000);
    chk("R10 chain irq", irq_n, 0);
    bus_addr = AW'('h05); bus_we = 1;
    #1 chk("R10 chain ack", dc_ack_o, 1);
    dc_req_i = 0;
    @(negedge clk) bus_we = 0;
    chk("R10 released", irq_n, 1);
    src_i = 32'h20; dc_req_i = 1;
    @(negedge clk);
    chk("R10 local beats chain", vec_o, 32'h1014);
    bus_we = 1;
    #1 chk("R10 no chain ack for local", dc_ack_o, 0);
    dc_req_i = 0; src_i = '0;
    @(negedge clk) bus_we = 0;
    chk("R9 released again", irq_n, 1);
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_enables;
    t_status;
    t_vectors;
    t_fiq;
    t_priority;
    t_chain;
    report;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    report;
  end
endmodule